// File: doc/BRIEF.md
# Jack Normalization Probe Detector

The block tells, for each of several analog jacks read by an external ADC, whether a patch cable is plugged in. It drives one pseudo-random probe bit onto the normalization contacts of every jack. When a jack is empty, the probe reaches the ADC through the normalization path, so the jack's readings follow the probe. When a cable is inserted, the cable's own signal replaces the probe.

The probe advances once per sample strobe. Every conversion the ADC delivers is also an ordinary CV reading, so no extra conversion, ping or idle gap is needed. For each channel, the block turns each reading into one bit with a threshold compare and compares that bit with the probe that was applied during the conversion. It counts disagreements over a window of 32 strobes. At the end of each window it decides whether the channel follows the probe closely enough to be called unpatched.

Top module: `jack_probe_detect`

## Requirements
- R1: While reset is asserted and after its release, `probe` equals bit 15 of the seed 0xACE1, which is 1. Every `unpatched` bit reads 0 until the first window of 32 strobes has completed.
- R2: The probe comes from a 16-bit shift register. On each cycle with `sample_stb` high, the register shifts left and takes bit15^bit13^bit12^bit10 into bit 0. `probe` is bit 15. On cycles without a strobe the register, and therefore `probe`, is unchanged.
- R3: A reading becomes the bit 1 when it is greater than or equal to `thresh`, and the bit 0 otherwise. A reading equal to `thresh` therefore counts as 1.
- R4: The reading presented with a strobe is compared against the value `probe` holds in that same cycle, before the probe advances.
- R5: Windows are 32 strobes long and are counted from reset. On the strobe that completes a window, each channel's flag is set to 1 if that channel had at most 2 mismatches in the window and to 0 otherwise. The mismatch count then restarts at zero.
- R6: `unpatched` changes only on the strobe that completes a window.
- R7: A channel with exactly 2 mismatches in a window is reported unpatched, and a channel with exactly 3 mismatches is reported patched.
- R8: All channels share one probe sequence and are judged independently. A channel carrying a signal unrelated to the probe is reported patched.
- R9: The mismatch count saturates instead of wrapping. A channel that disagrees on all 32 samples is reported patched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse marking a valid set of readings |
| adc_data | input | NUM_CH*ADC_W | Readings; channel c occupies bits c*ADC_W upward |
| thresh | input | ADC_W | Slicing threshold, normally mid-scale |
| probe | output | 1 | Probe bit driven onto the normalization contacts |
| unpatched | output | NUM_CH | Per-channel flag, 1 when no cable is detected |

## Verification
The hardest cases to reach from the ports are a window that holds exactly 2 or exactly 3 disagreements and a window whose count would overflow a narrow counter. Both need the stimulus to know the probe value of every sample in advance. The bench runs its own model of the probe sequence and builds each channel's readings from the predicted probe. One channel follows the probe exactly at the threshold boundary. Another injects 0 to 3 inverted samples per window at chosen positions. A third is inverted on every sample, and the strobe spacing varies, including back-to-back strobes.

// File: rtl/jack_probe_detect.sv
module jack_probe_detect #(
  parameter int NUM_CH = 4,
  parameter int ADC_W = 12,
  parameter int WIN = 32,
  parameter int MAX_MISS = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic [NUM_CH*ADC_W-1:0]  adc_data,
  input  logic [ADC_W-1:0]         thresh,
  output logic                     probe,
  output logic [NUM_CH-1:0]        unpatched
);
  localparam int CW = $clog2(WIN);
  localparam int MW = $clog2(MAX_MISS + 2);
  localparam logic [MW-1:0] MSAT = MW'(MAX_MISS + 1);
  localparam logic [MW-1:0] MLIM = MW'(MAX_MISS);

  logic [15:0]   lfsr;
  logic [CW-1:0] win_cnt;
  logic          win_end;

  assign probe   = lfsr[15];
  assign win_end = sample_stb && (win_cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= SEED;
      win_cnt <= '0;
    end else if (sample_stb) begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      win_cnt <= win_end ? '0 : win_cnt + CW'(1);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MW-1:0] miss, miss_nx;
    logic          hit, flag;

    assign hit     = (adc_data[c*ADC_W +: ADC_W] >= thresh) ^ probe;
    assign miss_nx = (hit && miss != MSAT) ? miss + MW'(1) : miss;
    assign unpatched[c] = flag;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        miss <= '0;
        flag <= 1'b0;
      end else if (sample_stb) begin
        if (win_end) begin
          flag <= (miss_nx <= MLIM);
          miss <= '0;
        end else begin
          miss <= miss_nx;
        end
      end
    end
  end
endmodule

// File: rtl/jack_probe_detect_chk.sv
module jack_probe_detect_chk #(
  parameter int NUM_CH = 4,
  parameter int CW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic              probe,
  input logic [NUM_CH-1:0] unpatched,
  input logic [15:0]       lfsr,
  input logic [CW-1:0]     win_cnt,
  input logic              win_end
);
  // R2
  probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(probe));

  // R2
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(unpatched));

  // R5
  win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !win_end) |=> win_cnt == CW'($past(win_cnt) + CW'(1)));

  // R5
  win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> win_cnt == '0);
endmodule

bind jack_probe_detect jack_probe_detect_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .probe(probe),
  .unpatched(unpatched), .lfsr(lfsr), .win_cnt(win_cnt), .win_end(win_end)
);

// File: tb/jack_probe_detect_tb.sv
`timescale 1ns/1ps
module jack_probe_detect_tb;
  localparam int NCH = 4, AW = 12, WIN = 32, MAXM = 2;

  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0;
  logic [NCH*AW-1:0] adc = '0;
  logic [AW-1:0] thr = 12'd2048;
  logic probe;
  logic [NCH-1:0] unp;

  always #2 clk = ~clk;

  jack_probe_detect #(.NUM_CH(NCH), .ADC_W(AW), .WIN(WIN), .MAX_MISS(MAXM)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(stb), .adc_data(adc),
    .thresh(thr), .probe(probe), .unpatched(unp));

  int n_chk = 0, n_fail = 0;
  bit [15:0] m_lfsr = 16'hACE1;
  int m_cnt = 0;
  int m_miss[NCH];
  bit [NCH-1:0] m_flag = '0;
  bit pend = 0;
  int pend_w = 0;
  int kl[6] = '{2, 3, 0, 2, 1, 3};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit s, input int w, input int i);
    logic [AW-1:0] v;
    bit p, b;
    @(negedge clk);
    chk(32'(probe), 32'(m_lfsr[15]), "R2 probe sequence");
    chk(32'(unp), 32'(m_flag), "R6 flag update");
    if (pend) begin
      // R4 R8: exact echo at the threshold boundary (R3) is unpatched
      chk(32'(unp[0]), 32'd1, "R4 R3 echo channel");
      // R7 / R5: 0..2 injected mismatches unpatched, 3 patched
      chk(32'(unp[1]), (kl[pend_w % 6] <= MAXM) ? 32'd1 : 32'd0, "R7 R5 injected mismatches");
      // R8: independent random signal
      chk(32'(unp[2]), 32'(m_flag[2]), "R8 random channel");
      // R9: all 32 mismatched is patched; echo afterwards is unpatched
      chk(32'(unp[3]), (pend_w < 5) ? 32'd0 : 32'd1, "R9 saturating count");
      pend = 0;
    end
    stb = s;
    if (s) begin
      p = m_lfsr[15];
      v = p ? thr : thr - 12'd1;
      adc[0*AW +: AW] = v;
      b = p ^ ((i % 11 == 5) && (i / 11 < kl[w % 6]));
      adc[1*AW +: AW] = b ? thr + 12'd100 : thr - 12'd200;
      adc[2*AW +: AW] = AW'($urandom_range(0, 4095));
      adc[3*AW +: AW] = ((w < 5) ? !p : p) ? 12'hFFF : 12'h000;
      for (int c = 0; c < NCH; c++)
        if ((adc[c*AW +: AW] >= thr) != p) m_miss[c]++;
      m_cnt++;
      if (m_cnt == WIN) begin
        for (int c = 0; c < NCH; c++) begin
          m_flag[c] = (m_miss[c] <= MAXM);
          m_miss[c] = 0;
        end
        m_cnt = 0;
        pend = 1;
        pend_w = w;
      end
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_miss[c] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(32'(probe), 32'd1, "R1 reset probe");
    chk(32'(unp), 32'd0, "R1 reset flags");
    rst_n = 1'b1;
    for (int w = 0; w < 10; w++) begin
      if (w == 4) thr = 12'd1000;
      for (int i = 0; i < WIN; i++) begin
        cycle(1'b1, w, i);
        for (int g = 0; g < (i + w) % 3; g++) cycle(1'b0, w, i);
      end
    end
    cycle(1'b0, 0, 0);
    cycle(1'b0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule